// File: doc/BRIEF.md
# Anticipating Complementary Gate Timer

This block produces two complementary gate drives for a pair of rectifier switches from a single synchronizing clock input that has already been sampled into the fast clock domain. Each cycle of the fast clock is one tick. The block counts the ticks that the sync input spends high and low. It then uses the length of the previous phase of the same polarity to predict when the next edge will arrive. Gate 1 follows the high phase and gate 2 follows the low phase. Each gate drops a set number of ticks before the predicted edge, so the switch is already off when the real transition arrives.

Gate 1 is released a fixed anticipation margin before the clock falls. Gate 2 is released before the clock rises, by a margin chosen with a two-bit select from three steps in ratio 1:2:3. An inhibit request forces gate 2 off so that the converter can run in discontinuous conduction and the freewheeling switch cannot pull current back from the output. Gate 2 still stays on for a minimum conduction time before inhibit can act.

After reset, and whenever enable is low, both gates stay off. They remain off until a full sync period has been measured, and the `measured` output reports when that has happened.

Top module: `sr_gate_timer`

## Requirements
- R1: While reset is asserted or `enable` is low, `gate1`, `gate2` and `measured` are all 0. Dropping `enable` clears all measurements.
- R2: A transition is a sampled `syncIn` value that differs from the previous tick's sample. `measured` rises on the tick after the third transition seen while `enable` is high, and it stays high until reset or until `enable` drops. Both gates stay low while `measured` is low.
- R3: Number the ticks of a high phase 1, 2, ... from the transition. Gate 1 is high exactly on ticks 2 through Lh − ANT1, where Lh is the length of the previous high phase. With a steady clock, gate 1 therefore falls ANT1 ticks before the falling transition.
- R4: Gate 2 behaves the same way in the low phase, using the previous low length Ll and a margin set by `antSel`. Code 0 gives 1 × ANT2_STEP ticks, code 1 gives 2 × ANT2_STEP, code 2 gives 3 × ANT2_STEP, and code 3 also gives 3 × ANT2_STEP.
- R5: When the previous phase length minus the margin is below 2, the matching gate stays low for the whole phase.
- R6: `gate1` and `gate2` are never high on the same tick. The gate that turns on does so no earlier than one tick after the other gate has turned off.
- R7: While `inhibit` is high, `gate2` is forced low once it has been high for MIN_ON consecutive ticks. After that it stays low for the rest of that low phase, even if `inhibit` is released.
- R8: Phase counts saturate at 2^CNT_W − 1 rather than wrapping. An overlong phase is recorded as that saturated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast tick clock |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Sampled synchronizing clock |
| antSel | input | 2 | Gate 2 anticipation select |
| inhibit | input | 1 | Request to force gate 2 off |
| enable | input | 1 | Run enable; low clears measurements |
| gate1 | output | 1 | Drive for the high-phase rectifier |
| gate2 | output | 1 | Drive for the low-phase (freewheeling) rectifier |
| measured | output | 1 | A full sync period has been measured |

## Verification
The bench builds the block with CNT_W = 6, ANT1 = 1, ANT2_STEP = 1 and MIN_ON = 4. The narrow counter lets a 100-tick phase reach saturation at 63, so the clamped measurement and its effect on the next phase are both exercised. With unit margins, the bench can use phases only a few ticks long to reach the case where a gate never turns on. A short MIN_ON lets inhibit cut gate 2 well inside a 20-tick low phase.

// File: rtl/antgate_pkg.sv
package antgate_pkg;
  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic rise;   // low-to-high transition on this tick's sample
    logic fall;   // high-to-low transition on this tick's sample
    logic level;  // current sampled level of the sync input
    logic clear;  // run disabled: drop all measurements
    logic armed;  // a full period has been measured
  } phaseStrb_t;
endpackage

// File: rtl/antgate_ctrl.sv
module antgate_ctrl
  import antgate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  logic       enable,
  output phaseStrb_t strb,
  output logic       measured
);
  localparam logic [1:0] SEEN_FULL = 2'd3;

  logic       syncD;
  logic [1:0] edgeSeen;
  logic       riseW, fallW;

  assign riseW = syncIn & ~syncD;
  assign fallW = ~syncIn & syncD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncD    <= 1'b0;
      edgeSeen <= '0;
    end else begin
      syncD <= syncIn;
      if (!enable)
        edgeSeen <= '0;
      else if ((riseW | fallW) && edgeSeen != SEEN_FULL)
        edgeSeen <= edgeSeen + 2'd1;
    end
  end

  assign measured = (edgeSeen == SEEN_FULL);

  always_comb begin
    strb.rise  = riseW;
    strb.fall  = fallW;
    strb.level = syncIn;
    strb.clear = ~enable;
    strb.armed = measured;
  end

  // R2: the measured flag only comes up right after a transition
  assert_armed_after_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(measured) |-> $past(riseW | fallW));

  // R1: a disabled run leaves the flag low on the following tick
  assert_disable_clears_R1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !measured);
endmodule

// File: rtl/antgate_dp.sv
module antgate_dp
  import antgate_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int ANT1      = 1,
  parameter int ANT2_STEP = 1,
  parameter int MIN_ON    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  phaseStrb_t strb,
  input  logic [1:0] antSel,
  input  logic       inhibit,
  output logic       gate1,
  output logic       gate2
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);
  localparam logic [CNT_W-1:0] FIRST_ON = CNT_W'(2);
  localparam logic [CNT_W-1:0] ANT1_C   = CNT_W'(ANT1);
  localparam logic [CNT_W-1:0] MIN_ON_C = CNT_W'(MIN_ON);

  logic [CNT_W-1:0] phaseCnt, lastHi, lastLo, onCnt;
  logic             killed;

  logic [CNT_W-1:0] cntNext, ant2Cnt, onNext;
  logic             anyEdge, g1Next, g2Cand, g2Next, killNow, killedNext;

  function automatic logic [CNT_W-1:0] offPoint(input logic [CNT_W-1:0] last,
                                                input logic [CNT_W-1:0] ant);
    return (last > ant) ? last - ant : '0;
  endfunction

  function automatic logic [CNT_W-1:0] satInc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + ONE_C;
  endfunction

  always_comb begin
    unique case (antSel)
      2'd0:    ant2Cnt = CNT_W'(ANT2_STEP);
      2'd1:    ant2Cnt = CNT_W'(2 * ANT2_STEP);
      default: ant2Cnt = CNT_W'(3 * ANT2_STEP);
    endcase
  end

  assign anyEdge = strb.rise | strb.fall;
  assign cntNext = anyEdge ? ONE_C : satInc(phaseCnt);

  always_comb begin
    g1Next = strb.armed & strb.level & (cntNext >= FIRST_ON)
           & (cntNext <= offPoint(lastHi, ANT1_C));
    g2Cand = strb.armed & ~strb.level & (cntNext >= FIRST_ON)
           & (cntNext <= offPoint(lastLo, ant2Cnt));
    killNow    = g2Cand & ~killed & inhibit & (onCnt >= MIN_ON_C);
    g2Next     = g2Cand & ~killed & ~killNow;
    onNext     = g2Next ? satInc(onCnt) : '0;
    killedNext = anyEdge ? 1'b0 : (killed | killNow);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      lastHi   <= '0;
      lastLo   <= '0;
      onCnt    <= '0;
      killed   <= 1'b0;
      gate1    <= 1'b0;
      gate2    <= 1'b0;
    end else if (strb.clear) begin
      phaseCnt <= '0;
      lastHi   <= '0;
      lastLo   <= '0;
      onCnt    <= '0;
      killed   <= 1'b0;
      gate1    <= 1'b0;
      gate2    <= 1'b0;
    end else begin
      phaseCnt <= cntNext;
      if (strb.fall) lastHi <= phaseCnt;
      if (strb.rise) lastLo <= phaseCnt;
      onCnt  <= onNext;
      killed <= killedNext;
      gate1  <= g1Next;
      gate2  <= g2Next;
    end
  end

  // R6: the two drives are never high together
  assert_dual_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(gate1 && gate2));

  // R6: gate 2 never comes up on the tick after gate 1 was high
  assert_dead_tick_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(gate2) |-> !$past(gate1));

  // R3: gate 1 sits inside its window of the current high phase
  assert_g1_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    gate1 |-> (phaseCnt >= FIRST_ON && phaseCnt <= lastHi));

  // R7: an inhibit cut happens only after the minimum on-time
  assert_min_on_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(gate2) && killed) |-> ($past(onCnt) >= MIN_ON_C));

  // R8: a saturated count holds until a transition or a clear
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (phaseCnt == CNT_MAX && !anyEdge && !strb.clear) |=> (phaseCnt == CNT_MAX));
endmodule

// File: rtl/sr_gate_timer.sv
module sr_gate_timer
  import antgate_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int ANT1      = 1,
  parameter int ANT2_STEP = 1,
  parameter int MIN_ON    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  logic [1:0] antSel,
  input  logic       inhibit,
  input  logic       enable,
  output logic       gate1,
  output logic       gate2,
  output logic       measured
);
  phaseStrb_t strb;

  antgate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .syncIn   (syncIn),
    .enable   (enable),
    .strb     (strb),
    .measured (measured)
  );

  antgate_dp #(
    .CNT_W     (CNT_W),
    .ANT1      (ANT1),
    .ANT2_STEP (ANT2_STEP),
    .MIN_ON    (MIN_ON)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .antSel  (antSel),
    .inhibit (inhibit),
    .gate1   (gate1),
    .gate2   (gate2)
  );
endmodule

// File: tb/sr_gate_timer_tb.sv
module sr_gate_timer_tb;
  localparam int CW   = 6;
  localparam int A1   = 1;
  localparam int A2S  = 1;
  localparam int MON  = 4;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rstN = 1'b0;
  logic       syncIn = 1'b0;
  logic [1:0] antSel = 2'd0;
  logic       inhibit = 1'b0;
  logic       enable = 1'b0;
  logic       gate1, gate2, measured;

  sr_gate_timer #(.CNT_W(CW), .ANT1(A1), .ANT2_STEP(A2S), .MIN_ON(MON)) u_dut (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .antSel(antSel),
    .inhibit(inhibit), .enable(enable),
    .gate1(gate1), .gate2(gate2), .measured(measured)
  );

  int    nChk = 0;
  int    nBad = 0;
  string tag = "R1";

  // Behavioural reference model: phase lengths kept as plain integers.
  int mPrev = 0, mLen = 0, mHiLen = 0, mLoLen = 0, mEdges = 0, mOnTime = 0;
  bit mG1 = 0, mG2 = 0, mCut = 0;

  always @(posedge clk) begin : refModel
    int  nLen, margin;
    bit  isEdge, ready, want2, cutNow, s;
    s = syncIn;
    if (!rstN || !enable) begin
      mLen = 0; mHiLen = 0; mLoLen = 0; mEdges = 0; mOnTime = 0;
      mG1 = 0; mG2 = 0; mCut = 0;
    end else begin
      isEdge = (int'(s) != mPrev);
      ready  = (mEdges >= 3);
      if (isEdge && !s) mHiLen = mLen;
      if (isEdge && s)  mLoLen = mLen;
      nLen   = isEdge ? 1 : ((mLen < MAXC) ? mLen + 1 : MAXC);
      margin = (antSel == 2'd0) ? A2S : (antSel == 2'd1) ? 2 * A2S : 3 * A2S;
      mG1    = ready && s && nLen >= 2 && nLen + A1 <= mHiLen;
      want2  = ready && !s && nLen >= 2 && nLen + margin <= mLoLen;
      cutNow = want2 && !mCut && inhibit && mOnTime >= MON;
      mG2    = want2 && !mCut && !cutNow;
      mOnTime = mG2 ? ((mOnTime < MAXC) ? mOnTime + 1 : MAXC) : 0;
      mCut   = isEdge ? 1'b0 : (mCut || cutNow);
      mLen   = nLen;
      if (isEdge && mEdges < 3) mEdges = mEdges + 1;
    end
    mPrev = rstN ? int'(s) : 0;
  end

  task automatic check(string req, string what, logic act, logic exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check(tag, "gate1", gate1, mG1);
    check(tag, "gate2", gate2, mG2);
    check(tag, "measured", measured, (mEdges >= 3));
    check("R6", "gates overlap", gate1 & gate2, 1'b0);
  end

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic phases(int hi, int lo, int n);
    for (int i = 0; i < n; i++) begin
      syncIn = 1'b1; ticks(hi);
      syncIn = 1'b0; ticks(lo);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    nBad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finishRun();
  end

  initial begin
    tag = "R1";
    ticks(3);
    rstN = 1'b1;
    ticks(4);                       // enable low: all outputs stay 0
    enable = 1'b1;
    tag = "R2";
    phases(10, 10, 3);              // measurement builds up
    tag = "R3";
    phases(10, 10, 3);
    phases(14, 8, 3);               // asymmetric duty
    tag = "R4";
    for (int s = 0; s < 4; s++) begin
      antSel = 2'(s);
      phases(9, 12, 3);
    end
    tag = "R5";
    antSel = 2'd0;
    phases(2, 12, 3);               // high phase too short for gate 1
    antSel = 2'd3;
    phases(10, 4, 3);               // low phase too short for gate 2
    tag = "R7";
    antSel = 2'd0;
    inhibit = 1'b1;
    phases(6, 20, 3);               // gate 2 cut after minimum on-time
    inhibit = 1'b0;
    phases(6, 20, 1);
    syncIn = 1'b1; ticks(6);
    syncIn = 1'b0; ticks(9);
    inhibit = 1'b1; ticks(1);       // late pulse cuts an already long-on gate
    inhibit = 1'b0; ticks(10);
    tag = "R8";
    syncIn = 1'b1; ticks(100);      // saturates the high count
    syncIn = 1'b0; ticks(10);
    phases(10, 10, 2);
    syncIn = 1'b1; ticks(10);
    syncIn = 1'b0; ticks(90);       // saturates the low count
    phases(10, 10, 2);
    tag = "R1";
    enable = 1'b0;
    ticks(6);
    tag = "R2";
    enable = 1'b1;
    phases(7, 7, 5);
    ticks(2);
    finishRun();
  end
endmodule